// File: doc/BRIEF.md
# Dual-Chamber Pacing Controller

This block sequences pacing for two heart chambers in strict alternation: first an upper-chamber (atrial) phase, then a lower-chamber (ventricular) phase, then back again. Each phase opens by reloading that chamber's countdown timer for one cycle. The controller then waits. A natural beat sensed in the current chamber cancels the pace for that phase and moves control straight to the other chamber. If no beat arrives before the timer reaches zero, the controller emits a one-cycle pace pulse and then moves to the other chamber.

There are two countdown timers, one per chamber. Each has a synchronous reload input and a zero flag, and each holds at zero until it is reloaded again. The reload count is a parameter. Its default is the number of ticks in 0.8 s at 50 MHz, and a bench can set a short count. The sense inputs are expected to be clean, synchronous pulses.

Top module: `dual_chamber_pacer`

## Requirements
- R1: While `rst` is high, and after `rst` is released, the controller is in the atrial timer-reload phase with both pace outputs low. With no sense activity, the first `pace_atr` pulse is seen in the (RELOAD_TICKS+2)-th cycle after the first clock edge at which `rst` is low.
- R2: In the atrial wait, with no atrial sense, `pace_atr` goes high exactly one cycle after the atrial timer reaches zero. The atrial wait therefore lasts RELOAD_TICKS+1 cycles.
- R3: Each pace pulse is exactly one clock cycle wide.
- R4: After an atrial pace, the ventricular phase starts. With no ventricular sense, `pace_ven` follows `pace_atr` by RELOAD_TICKS+3 cycles, and `pace_atr` follows `pace_ven` by RELOAD_TICKS+3 cycles.
- R5: An atrial sense during the atrial wait suppresses that phase's atrial pace. The next cycle is the ventricular timer-reload phase.
- R6: A ventricular sense during the ventricular wait suppresses that phase's ventricular pace. The next cycle is the atrial timer-reload phase.
- R7: When a sense and the zero flag of the same chamber coincide in the wait, the sense wins and no pace is issued.
- R8: A sense input has no effect outside its own chamber's wait phase. For example, `sense_atr` held high throughout the ventricular phase does not stop `pace_ven`.
- R9: `pace_atr` and `pace_ven` are never high in the same cycle.
- R10: Once a timer reaches zero, it stays at zero until its chamber's reload phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_atr | input | 1 | Sensed natural atrial beat |
| sense_ven | input | 1 | Sensed natural ventricular beat |
| pace_atr | output | 1 | One-cycle atrial pace pulse |
| pace_ven | output | 1 | One-cycle ventricular pace pulse |

## Verification
The bench aims a sense pulse at the exact cycle in which the wait timer reads zero. A design that checked the zero flag before the sense would issue a pace there and then also switch chambers. It holds the opposite chamber's sense high through a whole phase; a design that decoded the senses without regard to phase would lose the pace or jump phases. It measures the spacing between pulses and the delay after reset, which exposes an off-by-one in the reload value or in the wait exit. It also applies reset in the middle of the ventricular wait and checks that the atrial phase restarts cleanly.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    localparam int NUM_CHAMBERS = 2;
    localparam int CH_ATR       = 0;
    localparam int CH_VEN       = 1;

    typedef enum logic [2:0] {
        ST_RELOAD_ATR = 3'd0,
        ST_WAIT_ATR   = 3'd1,
        ST_PACE_ATR   = 3'd2,
        ST_RELOAD_VEN = 3'd3,
        ST_WAIT_VEN   = 3'd4,
        ST_PACE_VEN   = 3'd5
    } pace_state_e;

    // Counter width needed to hold a given reload count
    function automatic int count_width(input int ticks);
        return (ticks < 2) ? 1 : $clog2(ticks + 1);
    endfunction

endpackage

// File: rtl/pace_countdown.sv
module pace_countdown #(
    parameter int RELOAD_TICKS = 40_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic reload,
    output logic at_zero
);
    localparam int CW = pacer_pkg::count_width(RELOAD_TICKS);
    localparam logic [CW-1:0] LOAD_VAL = CW'(RELOAD_TICKS);

    logic [CW-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            remaining <= LOAD_VAL;
        end else if (remaining != '0) begin
            remaining <= remaining - 1'b1;
        end
    end

    assign at_zero = (remaining == '0);
endmodule

// File: rtl/pacer_fsm.sv
module pacer_fsm
    import pacer_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CHAMBERS-1:0] sense,
    input  logic [NUM_CHAMBERS-1:0] tmr_zero,
    output logic [NUM_CHAMBERS-1:0] tmr_reload,
    output logic [NUM_CHAMBERS-1:0] pace,
    output pace_state_e             state
);
    pace_state_e nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RELOAD_ATR;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RELOAD_ATR: nxt = ST_WAIT_ATR;
            ST_WAIT_ATR: begin
                if (sense[CH_ATR])         nxt = ST_RELOAD_VEN;
                else if (tmr_zero[CH_ATR]) nxt = ST_PACE_ATR;
            end
            ST_PACE_ATR:   nxt = ST_RELOAD_VEN;
            ST_RELOAD_VEN: nxt = ST_WAIT_VEN;
            ST_WAIT_VEN: begin
                if (sense[CH_VEN])         nxt = ST_RELOAD_ATR;
                else if (tmr_zero[CH_VEN]) nxt = ST_PACE_VEN;
            end
            ST_PACE_VEN:   nxt = ST_RELOAD_ATR;
            default:       nxt = ST_RELOAD_ATR;
        endcase
    end

    always_comb begin
        tmr_reload = '0;
        pace       = '0;
        case (state)
            ST_RELOAD_ATR: tmr_reload[CH_ATR] = 1'b1;
            ST_RELOAD_VEN: tmr_reload[CH_VEN] = 1'b1;
            ST_PACE_ATR:   pace[CH_ATR]       = 1'b1;
            ST_PACE_VEN:   pace[CH_VEN]       = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dual_chamber_pacer.sv
module dual_chamber_pacer
    import pacer_pkg::*;
#(
    parameter int RELOAD_TICKS = 40_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic sense_atr,
    input  logic sense_ven,
    output logic pace_atr,
    output logic pace_ven
);
    logic [NUM_CHAMBERS-1:0] sense_vec;
    logic [NUM_CHAMBERS-1:0] tmr_zero;
    logic [NUM_CHAMBERS-1:0] tmr_reload;
    logic [NUM_CHAMBERS-1:0] pace_vec;
    pace_state_e             fsm_state;

    assign sense_vec[CH_ATR] = sense_atr;
    assign sense_vec[CH_VEN] = sense_ven;

    for (genvar ch = 0; ch < NUM_CHAMBERS; ch++) begin : g_timer
        pace_countdown #(.RELOAD_TICKS(RELOAD_TICKS)) tmr_i (
            .clk     (clk),
            .rst     (rst),
            .reload  (tmr_reload[ch]),
            .at_zero (tmr_zero[ch])
        );
    end

    pacer_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .sense      (sense_vec),
        .tmr_zero   (tmr_zero),
        .tmr_reload (tmr_reload),
        .pace       (pace_vec),
        .state      (fsm_state)
    );

    assign pace_atr = pace_vec[CH_ATR];
    assign pace_ven = pace_vec[CH_VEN];
endmodule

// File: rtl/pacer_checker.sv
module pacer_checker
    import pacer_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        sense_atr,
    input logic        sense_ven,
    input logic        pace_atr,
    input logic        pace_ven,
    input pace_state_e st,
    input logic [1:0]  tmr_zero
);
    AST_RESET_ENTRY: assert property (@(posedge clk)
        rst |=> (st == ST_RELOAD_ATR && !pace_atr && !pace_ven)); // R1

    AST_PACE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(pace_atr && pace_ven)); // R9

    AST_ATR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pace_atr |=> !pace_atr); // R3

    AST_VEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pace_ven |=> !pace_ven); // R3

    AST_ATR_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT_ATR && !sense_atr && tmr_zero[0]) |=> pace_atr); // R2

    AST_ATR_TO_VEN: assert property (@(posedge clk) disable iff (rst)
        pace_atr |=> (st == ST_RELOAD_VEN)); // R4

    AST_ATR_SENSE_WINS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT_ATR && sense_atr) |=> (st == ST_RELOAD_VEN && !pace_atr)); // R5

    AST_VEN_SENSE_WINS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT_VEN && sense_ven) |=> (st == ST_RELOAD_ATR && !pace_ven)); // R6

    AST_SENSE_OVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT_ATR && sense_atr && tmr_zero[0]) |=> !pace_atr); // R7

    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tmr_zero[1] && st != ST_RELOAD_VEN) |=> tmr_zero[1]); // R10
endmodule

bind dual_chamber_pacer pacer_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .sense_atr (sense_atr),
    .sense_ven (sense_ven),
    .pace_atr  (pace_atr),
    .pace_ven  (pace_ven),
    .st        (fsm_state),
    .tmr_zero  (tmr_zero)
);

// File: tb/dual_chamber_pacer_tb_top.sv
module dual_chamber_pacer_tb_top;
    localparam int R = 6;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sense_atr = 1'b0;
    logic sense_ven = 1'b0;
    logic pace_atr, pace_ven;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // reference model: phase 0..5 = reloadA, waitA, paceA, reloadV, waitV, paceV
    int m_ph = 0;
    int m_ca = R;
    int m_cv = R;

    always #10 clk = ~clk;

    dual_chamber_pacer #(.RELOAD_TICKS(R)) dut_i (
        .clk(clk), .rst(rst),
        .sense_atr(sense_atr), .sense_ven(sense_ven),
        .pace_atr(pace_atr), .pace_ven(pace_ven)
    );

    function automatic int next_phase(int ph, logic sa, logic sv, int ca, int cv);
        case (ph)
            0: return 1;
            1: return sa ? 3 : (ca == 0 ? 2 : 1);
            2: return 3;
            3: return 4;
            4: return sv ? 0 : (cv == 0 ? 5 : 4);
            default: return 0;
        endcase
    endfunction

    function automatic int next_count(int c, logic reload);
        return reload ? R : (c > 0 ? c - 1 : 0);
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ph = 0; m_ca = R; m_cv = R;
    endtask

    // called at a negedge: drive inputs, advance model, wait one cycle, compare
    task automatic step(logic sa, logic sv, string req);
        int np;
        sense_atr = sa;
        sense_ven = sv;
        np = next_phase(m_ph, sa, sv, m_ca, m_cv);
        m_ca = next_count(m_ca, m_ph == 0);
        m_cv = next_count(m_cv, m_ph == 3);
        m_ph = np;
        @(negedge clk);
        check(req, pace_atr, m_ph == 2, "pace_atr");
        check(req, pace_ven, m_ph == 5, "pace_ven");
        check("R9", pace_atr && pace_ven, 1'b0, "both paces");
    endtask

    task automatic do_reset(int n);
        rst = 1'b1;
        sense_atr = 1'b0;
        sense_ven = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R1", pace_atr, 1'b0, "pace_atr in reset");
            check("R1", pace_ven, 1'b0, "pace_ven in reset");
        end
        model_reset();
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t_first;
        int t_atr;
        int t_ven;
        int gap;

        // R1: reset state and first pace delay
        do_reset(3);
        t_first = 0;
        for (int i = 1; i <= 2 * R + 10 && t_first == 0; i++) begin
            step(1'b0, 1'b0, "R1");
            if (pace_atr) t_first = i;
        end
        check("R1", t_first == R + 2, 1'b1, "first atrial pace delay");

        // R2/R3/R4: undisturbed pacing, spacing between pulses
        t_atr = 0; t_ven = 0; gap = 0;
        for (int i = 1; i <= 4 * (R + 4); i++) begin
            step(1'b0, 1'b0, "R2");
            if (pace_ven && t_ven == 0) begin
                t_ven = i;
                gap = i;
            end
            if (pace_atr && t_ven != 0 && t_atr == 0) t_atr = i;
        end
        check("R4", (t_atr - t_ven) == R + 3, 1'b1, "ven-to-atr spacing");
        check("R4", gap == R + 3, 1'b1, "atr-to-ven spacing");

        // R5: atrial sense mid-wait suppresses atrial pace
        do_reset(2);
        step(1'b0, 1'b0, "R5");
        step(1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, "R5");
        for (int i = 0; i < R + 4; i++) step(1'b0, 1'b0, "R5");

        // R6: ventricular sense mid-wait suppresses ventricular pace
        do_reset(2);
        while (m_ph != 4) step(1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, "R6");
        for (int i = 0; i < R + 4; i++) step(1'b0, 1'b0, "R6");

        // R7: sense exactly when atrial timer is at zero
        do_reset(2);
        while (!(m_ph == 1 && m_ca == 0)) step(1'b0, 1'b0, "R7");
        step(1'b1, 1'b0, "R7");
        check("R7", pace_atr, 1'b0, "pace after sense at zero");
        for (int i = 0; i < R + 4; i++) step(1'b0, 1'b0, "R7");

        // R8: atrial sense held throughout ventricular phase, ventricular pace still issued
        while (m_ph != 3) step(1'b0, 1'b0, "R8");
        t_ven = 0;
        for (int i = 0; i < R + 4; i++) begin
            step(1'b1, 1'b0, "R8");
            if (pace_ven) t_ven = 1;
        end
        check("R8", t_ven == 1, 1'b1, "ven pace with atrial sense held");

        // R10 + R1: reset mid ventricular wait, timers hold at zero across long waits
        while (m_ph != 4) step(1'b0, 1'b0, "R10");
        step(1'b0, 1'b0, "R10");
        do_reset(1);
        for (int i = 0; i < 3 * (R + 4); i++) step(1'b0, 1'b0, "R10");

        // random mix
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 12) == 0, ($urandom % 12) == 0, "R9");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule